// File: doc/BRIEF.md
# Eight-Line GPIO Port with Address-Masked Data Access

This block is an 8-line general-purpose I/O port behind a small memory-mapped register interface. Each pin has a data bit and a direction bit. The data register sits behind a 1 KB window. Address bits [9:2] of an access in that window act as a per-pin mask, so software can read or change a chosen set of pins in one access without a read-modify-write.

The level driven onto each line is resolved from four things: the direction bit, the data bit, a pull-up mask and a pull-down mask. An output pin drives its data bit. An input pin with a pull-up drives 1, and an input pin with only a pull-down drives 0. An input pin with neither pull keeps its last resolved level.

The pull masks come from one of two sources, chosen by a parameter:

- In the programmable mode they are software registers. A bank of plain 8-bit pad-setting registers is also present in this mode: drive strength, open drain, slew, digital enable and analog select.
- In the fixed mode the pull masks are parameters, and the pad-setting offsets are unmapped.

External levels are sampled into the data register for input pins. Twelve identification bytes can be read at the top of the 4 KB space.

Top module: `gpio_mask_port`

## Requirements
- R1: A read in byte offsets 0x000–0x3FF returns the data register ANDed with address bits [9:2] in rdata[7:0], with all other bits 0. bus_rdata shows the result in the cycle after the access.
- R2: A write in offsets 0x000–0x3FF changes only data bits whose address-mask bit is 1 and whose direction bit is 1. Such a bit takes the value of the matching bit of bus_wdata. All other data bits are unchanged.
- R3: On every clock, each data bit whose direction bit is 0 takes the level on the matching pin_in line. pin_in has no effect on data bits whose direction bit is 1.
- R4: The direction register is at offset 0x400. It stores bus_wdata[7:0], reads back that value, and resets to 0. A 1 makes the pin an output. One cycle after the registers change, each output pin's pin_out bit equals its data bit.
- R5: An input pin with its pull-up bit set drives 1 on pin_out. An input pin with only its pull-down bit set drives 0. An input pin with neither bit set holds its previous pin_out level. If both bits are set, the pull-up wins.
- R6: With PROG_PULL=1, the pull-up mask is a register at 0x510 and the pull-down mask is a register at 0x514. Both are 8 bits wide and reset to 0. With PROG_PULL=0, the pull masks are the parameters FIX_PULLUP and FIX_PULLDN.
- R7: With PROG_PULL=1, seven 8-bit setting registers store bus_wdata[7:0] and read it back. They are at 0x500 (2 mA drive, resets to 0xFF), 0x504, 0x508, 0x50C, 0x518, 0x51C and 0x528, and all except 0x500 reset to 0.
- R8: With PROG_PULL=0, every offset from 0x500 to 0x528 is unmapped.
- R9: A read at 0xFD0 + 4·i (i = 0..11) returns identification byte i. The bytes are 00,00,00,00,3A,V,02,00,5A,C3,81,2E, where V is 0x28 with PROG_PULL=1 and 0x17 with PROG_PULL=0.
- R10: A read of an unmapped offset returns 0, and a write to one changes nothing. For either kind of access, bus_err is 1 for exactly the one cycle after the access. Unmapped offsets include misaligned offsets and 0x404–0x4FC. bus_err stays 0 for mapped accesses.
- R11: During and right after reset, pin_out equals the reset pull-up mask: 0 with PROG_PULL=1, FIX_PULLUP with PROG_PULL=0. The data register also resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after an access to an unmapped offset |
| pin_in | input | 8 | External line levels |
| pin_out | output | 8 | Resolved line levels |

## Verification
Two functions can act on the data register in the same cycle:

- a masked data write, which acts on output pins;
- input sampling from pin_in, which acts on input pins.

The bench provokes this by writing the data window while pin_in holds a pattern that differs on the output pins, across all 256 address masks. It judges the result by reading back the full register: the output pins must carry the written bits and the input pins the sampled level.

It also checks that pin_out follows the arithmetic resolution model. This covers pins that change between driven, pulled and floating in consecutive writes.

// File: rtl/gpio_mask_pkg.sv
// Package: shared offsets, selector encoding and constant tables for the
// address-masked GPIO port. Assumes a 4 KB register space addressed by bytes.
package gpio_mask_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int CFG_N  = 7;

    localparam logic [ADDR_W-1:0] OFF_DIR  = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_DRV2 = 12'h500;
    localparam logic [ADDR_W-1:0] OFF_DRV4 = 12'h504;
    localparam logic [ADDR_W-1:0] OFF_DRV8 = 12'h508;
    localparam logic [ADDR_W-1:0] OFF_ODRN = 12'h50C;
    localparam logic [ADDR_W-1:0] OFF_PUP  = 12'h510;
    localparam logic [ADDR_W-1:0] OFF_PDN  = 12'h514;
    localparam logic [ADDR_W-1:0] OFF_SLEW = 12'h518;
    localparam logic [ADDR_W-1:0] OFF_DEN  = 12'h51C;
    localparam logic [ADDR_W-1:0] OFF_ANA  = 12'h528;
    localparam logic [ADDR_W-1:0] OFF_ID   = 12'hFD0;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_DIR, SEL_DRV2, SEL_DRV4, SEL_DRV8, SEL_ODRN,
        SEL_PUP, SEL_PDN, SEL_SLEW, SEL_DEN, SEL_ANA, SEL_ID
    } reg_sel_e;

    // Storage slot of a pad-setting register; CFG_N means "not a setting".
    function automatic logic [2:0] cfg_slot(input reg_sel_e s);
        case (s)
            SEL_DRV2: return 3'd0;
            SEL_DRV4: return 3'd1;
            SEL_DRV8: return 3'd2;
            SEL_ODRN: return 3'd3;
            SEL_SLEW: return 3'd4;
            SEL_DEN:  return 3'd5;
            SEL_ANA:  return 3'd6;
            default:  return 3'd7;
        endcase
    endfunction

    // Reset value of a setting slot: the 2 mA drive slot starts all ones.
    function automatic logic [7:0] cfg_rst(input int k);
        return (k == 0) ? 8'hFF : 8'h00;
    endfunction

    // Identification byte table; one byte depends on the pull mode.
    function automatic logic [7:0] id_byte(input logic [3:0] idx, input logic prog);
        case (idx)
            4'd4:    return 8'h3A;
            4'd5:    return prog ? 8'h28 : 8'h17;
            4'd6:    return 8'h02;
            4'd8:    return 8'h5A;
            4'd9:    return 8'hC3;
            4'd10:   return 8'h81;
            4'd11:   return 8'h2E;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/gpio_mask_decode.sv
// Address decoder: maps a byte offset to a register selector and an
// identification index. Pure combinational. Assumes NPINS + 2 < ADDR_W so the
// masked data window sits at the bottom of the space. In fixed-pull mode the
// pad-setting offsets decode to SEL_NONE.
module gpio_mask_decode
    import gpio_mask_pkg::*;
#(
    parameter int NPINS     = 8,
    parameter bit PROG_PULL = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [3:0]        id_idx
);
    localparam int WIN_LSB = NPINS + 2;

    logic     in_win;
    logic     in_id;
    reg_sel_e cfg_sel;

    assign in_win = (addr[ADDR_W-1:WIN_LSB] == '0);
    assign in_id  = (addr >= OFF_ID);
    // Word index from the start of the identification block.
    assign id_idx = addr[5:2] - 4'd4;

    generate
        if (PROG_PULL) begin : g_cfg_dec
            // Purpose: decode the pad-setting and pull registers.
            always_comb begin
                case (addr)
                    OFF_DRV2: cfg_sel = SEL_DRV2;
                    OFF_DRV4: cfg_sel = SEL_DRV4;
                    OFF_DRV8: cfg_sel = SEL_DRV8;
                    OFF_ODRN: cfg_sel = SEL_ODRN;
                    OFF_PUP:  cfg_sel = SEL_PUP;
                    OFF_PDN:  cfg_sel = SEL_PDN;
                    OFF_SLEW: cfg_sel = SEL_SLEW;
                    OFF_DEN:  cfg_sel = SEL_DEN;
                    OFF_ANA:  cfg_sel = SEL_ANA;
                    default:  cfg_sel = SEL_NONE;
                endcase
            end
        end else begin : g_cfg_none
            assign cfg_sel = SEL_NONE;
        end
    endgenerate

    // Purpose: priority decode of the whole space.
    always_comb begin
        if (in_win)                sel = SEL_DATA;
        else if (addr == OFF_DIR)  sel = SEL_DIR;
        else if (in_id)            sel = SEL_ID;
        else                       sel = cfg_sel;
    end

endmodule

// File: rtl/gpio_mask_regs.sv
// Register file: data, direction, pull masks and pad settings, plus the read
// mux. Assumes NPINS <= 8 since every field is byte wide. Input pins sample
// pin_in on every clock; output pins change only through masked writes. In
// fixed-pull mode the pull masks are parameters and no setting storage exists.
module gpio_mask_regs
    import gpio_mask_pkg::*;
#(
    parameter int               NPINS      = 8,
    parameter bit               PROG_PULL  = 1'b1,
    parameter logic [NPINS-1:0] FIX_PULLUP = '1,
    parameter logic [NPINS-1:0] FIX_PULLDN = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [3:0]       id_idx,
    input  logic [NPINS-1:0] addr_mask,
    input  logic [7:0]       wbyte,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] data_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] pu_eff,
    output logic [NPINS-1:0] pd_eff,
    output logic [7:0]       rd_val
);
    logic             data_wr;
    logic [7:0]       cfg_rd;
    logic [2:0]       slot;

    assign data_wr = wr_en && (sel == SEL_DATA);
    assign slot    = cfg_slot(sel);

    // Purpose: direction register, low byte only.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= '0;
        else if (wr_en && (sel == SEL_DIR))  dir_q <= wbyte[NPINS-1:0];
    end

    // One data bit per pin: inputs track the line, outputs take masked writes.
    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_data
            // Purpose: update data bit i from the line or from a masked write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    data_q[i] <= 1'b0;
                else if (!dir_q[i])
                    data_q[i] <= pin_in[i];
                else if (data_wr && addr_mask[i])
                    data_q[i] <= wbyte[i];
            end
        end
    endgenerate

    generate
        if (PROG_PULL) begin : g_prog
            logic [NPINS-1:0] pu_q;
            logic [NPINS-1:0] pd_q;
            logic [7:0]       cfg_q [CFG_N];

            // Purpose: software-written pull masks.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pu_q <= '0;
                    pd_q <= '0;
                end else if (wr_en) begin
                    if (sel == SEL_PUP) pu_q <= wbyte[NPINS-1:0];
                    if (sel == SEL_PDN) pd_q <= wbyte[NPINS-1:0];
                end
            end

            for (genvar k = 0; k < CFG_N; k++) begin : g_cfg
                // Purpose: pad-setting byte k.
                always_ff @(posedge clk) begin
                    if (!rst_n)                         cfg_q[k] <= cfg_rst(k);
                    else if (wr_en && slot == 3'(k))    cfg_q[k] <= wbyte;
                end
            end

            // Purpose: select the addressed setting or pull mask for reading.
            always_comb begin
                cfg_rd = 8'h00;
                for (int k = 0; k < CFG_N; k++)
                    if (slot == 3'(k)) cfg_rd = cfg_q[k];
                if (sel == SEL_PUP) cfg_rd = 8'(pu_q);
                if (sel == SEL_PDN) cfg_rd = 8'(pd_q);
            end

            assign pu_eff = pu_q;
            assign pd_eff = pd_q;
        end else begin : g_fixed
            assign pu_eff = FIX_PULLUP;
            assign pd_eff = FIX_PULLDN;
            assign cfg_rd = 8'h00;
        end
    endgenerate

    // Purpose: read mux over the decoded register.
    always_comb begin
        case (sel)
            SEL_DATA: rd_val = 8'(data_q & addr_mask);
            SEL_DIR:  rd_val = 8'(dir_q);
            SEL_ID:   rd_val = id_byte(id_idx, PROG_PULL);
            SEL_NONE: rd_val = 8'h00;
            default:  rd_val = cfg_rd;
        endcase
    end

endmodule

// File: rtl/gpio_mask_resolve.sv
// Line resolver: registers the level driven on each line. Outputs drive the
// data bit, pulled inputs drive their pull level (pull-up first), and inputs
// without pulls hold the previous level. Assumes pull masks are stable or
// legal; a bit set in both is treated as pulled up.
module gpio_mask_resolve #(
    parameter int               NPINS   = 8,
    parameter logic [NPINS-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] data_q,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] pu_eff,
    input  logic [NPINS-1:0] pd_eff,
    output logic [NPINS-1:0] line_q
);
    logic [NPINS-1:0] floating;
    logic [NPINS-1:0] line_d;

    assign floating = ~(pu_eff | pd_eff) & ~dir_q;

    // Purpose: combine driven, pulled and held contributions.
    always_comb begin
        line_d = (data_q & dir_q) | (pu_eff & ~dir_q) | (line_q & floating);
    end

    // Purpose: hold the resolved level; reset to the pull-up pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= RST_VAL;
        else        line_q <= line_d;
    end

endmodule

// File: rtl/gpio_mask_port.sv
// Top: address-masked GPIO port. A one-cycle request (bus_sel with bus_wr)
// reads or writes; read data and the unmapped-access flag are registered and
// appear the cycle after. Assumes at most one access per cycle and NPINS <= 8.
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int               NPINS      = 8,
    parameter bit               PROG_PULL  = 1'b1,
    parameter logic [NPINS-1:0] FIX_PULLUP = '1,
    parameter logic [NPINS-1:0] FIX_PULLDN = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out
);
    localparam logic [NPINS-1:0] LINE_RST = PROG_PULL ? '0 : FIX_PULLUP;

    reg_sel_e         sel;
    logic [3:0]       id_idx;
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] pu_eff;
    logic [NPINS-1:0] pd_eff;
    logic [7:0]       rd_val;
    logic             wr_en;
    logic             wdata_unused;

    assign wr_en        = bus_sel && bus_wr;
    assign wdata_unused = ^bus_wdata[DATA_W-1:8];

    gpio_mask_decode #(
        .NPINS     (NPINS),
        .PROG_PULL (PROG_PULL)
    ) u_decode (
        .addr   (bus_addr),
        .sel    (sel),
        .id_idx (id_idx)
    );

    gpio_mask_regs #(
        .NPINS      (NPINS),
        .PROG_PULL  (PROG_PULL),
        .FIX_PULLUP (FIX_PULLUP),
        .FIX_PULLDN (FIX_PULLDN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .sel       (sel),
        .id_idx    (id_idx),
        .addr_mask (bus_addr[NPINS+1:2]),
        .wbyte     (bus_wdata[7:0]),
        .pin_in    (pin_in),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .pu_eff    (pu_eff),
        .pd_eff    (pd_eff),
        .rd_val    (rd_val)
    );

    gpio_mask_resolve #(
        .NPINS   (NPINS),
        .RST_VAL (LINE_RST)
    ) u_resolve (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_q (data_q),
        .dir_q  (dir_q),
        .pu_eff (pu_eff),
        .pd_eff (pd_eff),
        .line_q (pin_out)
    );

    // Purpose: register read data and the unmapped-access pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= (bus_sel && !bus_wr) ? DATA_W'(rd_val) : '0;
            bus_err   <= bus_sel && (sel == SEL_NONE);
        end
    end

endmodule

// File: rtl/gpio_mask_port_chk.sv
// Checker: temporal properties of the GPIO port, bound into every instance.
// Observes ports and the register outputs that feed the line resolver.
module gpio_mask_port_chk
    import gpio_mask_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  data_q,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  pu_eff,
    input logic [NPINS-1:0]  pd_eff
);
    logic             in_win;
    logic [NPINS-1:0] amask;
    logic [NPINS-1:0] flt;
    logic [NPINS-1:0] pulled_hi;

    assign in_win    = (bus_addr[ADDR_W-1:NPINS+2] == '0);
    assign amask     = bus_addr[NPINS+1:2];
    assign flt       = ~dir_q & ~pu_eff & ~pd_eff;
    assign pulled_hi = ~dir_q & pu_eff;

    // R1: masked read leaves unmasked and upper bits at zero.
    a_r1_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && in_win) |=>
            (((bus_rdata[NPINS-1:0] & ~$past(amask)) == '0) &&
             (bus_rdata[DATA_W-1:NPINS] == '0)));

    // R2: a data write never touches unmasked output bits.
    a_r2_write_scope: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && in_win) |=>
            (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(amask)) == '0));

    // R3: output-pin data bits stay put without a data write.
    a_r3_outputs_ignore_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(bus_sel && bus_wr && in_win)) |=>
            ((data_q & $past(dir_q)) == ($past(data_q) & $past(dir_q))));

    // R4: output pins drive the data bit one cycle later.
    a_r4_output_drive: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pin_out & $past(dir_q)) == ($past(data_q) & $past(dir_q))));

    // R5: pulled-up inputs drive one.
    a_r5_pull_high: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pin_out & $past(pulled_hi)) == $past(pulled_hi)));

    // R5: floating inputs keep their level.
    a_r5_float_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((pin_out ^ $past(pin_out)) & $past(flt)) == '0));

    // R10: the error pulse follows an access and carries zero read data.
    a_r10_err_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ($past(bus_sel) && (bus_rdata == '0)));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .pin_out   (pin_out),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .pu_eff    (pu_eff),
    .pd_eff    (pd_eff)
);

// File: tb/gpio_mask_port_bench.sv
// Bench: two instances share one bus, one with programmable pulls and one
// with fixed pulls (up 0xF0, down 0x0C). An arithmetic model tracks data,
// direction, pulls and resolved lines of both.
module gpio_mask_port_bench;
    localparam int CLK_PER = 10;
    localparam logic [7:0] FPU = 8'hF0;
    localparam logic [7:0] FPD = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  pin_in = '0;
    logic [31:0] rdata_p, rdata_f;
    logic        err_p, err_f;
    logic [7:0]  pout_p, pout_f;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  md = '0, mdir = '0, mpu = '0, mpd = '0, mpin = '0;
    logic [7:0]  mout = '0, mout_f = FPU;
    logic [31:0] cap_rd, cap_rd_f;
    logic        cap_err, cap_err_f;

    always #(CLK_PER/2) clk = ~clk;

    gpio_mask_port u_gpio_mask_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_p),
        .bus_err(err_p), .pin_in(pin_in), .pin_out(pout_p)
    );

    gpio_mask_port #(.PROG_PULL(1'b0), .FIX_PULLUP(FPU), .FIX_PULLDN(FPD)) u_gpio_mask_port_fix (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_f),
        .bus_err(err_f), .pin_in(pin_in), .pin_out(pout_f)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] id_exp(input int i, input bit prog);
        logic [7:0] t [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h3A, 8'h28,
                               8'h02, 8'h00, 8'h5A, 8'hC3, 8'h81, 8'h2E};
        if (i == 5 && !prog) return 8'h17;
        return t[i];
    endfunction

    // One access, then one idle cycle so the resolved lines settle.
    task automatic acc(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        cap_rd = rdata_p; cap_err = err_p; cap_rd_f = rdata_f; cap_err_f = err_f;
        @(negedge clk);
    endtask

    task automatic remodel();
        md     = (md & mdir) | (mpin & ~mdir);
        mout   = (md & mdir) | (mpu & ~mdir) | (mout & ~(mpu | mpd) & ~mdir);
        mout_f = (md & mdir) | (FPU & ~mdir) | (mout_f & ~(FPU | FPD) & ~mdir);
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d);
        acc(1'b1, a, d);
        if (a < 12'h400) begin
            logic [7:0] m;
            m  = a[9:2] & mdir;
            md = (md & ~m) | (d[7:0] & m);
        end else if (a == 12'h400) mdir = d[7:0];
        else if (a == 12'h510) mpu = d[7:0];
        else if (a == 12'h514) mpd = d[7:0];
        remodel();
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v; mpin = v;
        @(negedge clk);
        @(negedge clk);
        remodel();
    endtask

    task automatic chk_lines(input string req);
        check(req, {24'b0, pout_p}, {24'b0, mout});
        check(req, {24'b0, pout_f}, {24'b0, mout_f});
    endtask

    initial begin
        #(CLK_PER * 190000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] cfg_off [7] = '{12'h500, 12'h504, 12'h508, 12'h50C, 12'h518, 12'h51C, 12'h528};
        logic [11:0] bad_off [9] = '{12'h404, 12'h41C, 12'h520, 12'h524, 12'h52C, 12'h7FC, 12'h401, 12'h900, 12'hFCC};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state of lines, read data and error flag.
        check("R11 line reset prog", {24'b0, pout_p}, 32'h0);
        check("R11 line reset fixed", {24'b0, pout_f}, {24'b0, FPU});
        check("R11 rdata reset", rdata_p, 32'h0);
        check("R10 err idle", {31'b0, err_p}, 32'h0);
        acc(1'b0, 12'h3FC, 0);
        check("R11 data reset", cap_rd, 32'h0);
        acc(1'b0, 12'h400, 0);
        check("R4 dir reset", cap_rd, 32'h0);

        // R7 reset values; R8 fixed mode unmapped.
        for (int k = 0; k < 7; k++) begin
            acc(1'b0, cfg_off[k], 0);
            check("R7 setting reset", cap_rd, (k == 0) ? 32'hFF : 32'h0);
            check("R7 no err", {31'b0, cap_err}, 32'h0);
            check("R8 fixed read zero", cap_rd_f, 32'h0);
            check("R8 fixed err", {31'b0, cap_err_f}, 32'h1);
        end

        // R9: identification bytes in both modes.
        for (int i = 0; i < 12; i++) begin
            acc(1'b0, 12'hFD0 + 12'(4 * i), 0);
            check("R9 id prog", cap_rd, {24'b0, id_exp(i, 1'b1)});
            check("R9 id fixed", cap_rd_f, {24'b0, id_exp(i, 1'b0)});
        end

        // R1: all 256 read masks over sampled inputs.
        set_pins(8'hA5);
        for (int m = 0; m < 256; m++) begin
            acc(1'b0, {2'b00, 8'(m), 2'b00}, 0);
            check("R1 masked read", cap_rd, {24'b0, 8'hA5 & 8'(m)});
            check("R1 masked read fixed", cap_rd_f, {24'b0, 8'hA5 & 8'(m)});
        end

        // R3: line levels ignored on outputs, sampled on inputs.
        wreg(12'h400, 32'h0F);
        wreg(12'h3FC, 32'hFFFF_FF5A);
        set_pins(8'hFF);
        acc(1'b0, 12'h3FC, 0);
        check("R3 inputs sampled, outputs kept", cap_rd, 32'hFA);
        chk_lines("R4 lines after mixed dir");

        // R2: write sweep over all masks with pins differing on outputs.
        wreg(12'h400, 32'h5A);
        set_pins(8'h33);
        for (int m = 0; m < 256; m++) begin
            wreg({2'b00, 8'(m), 2'b00}, 32'(((m * 37) ^ 8'h6C) & 8'hFF));
            acc(1'b0, 12'h3FC, 0);
            check("R2 masked write", cap_rd, {24'b0, md});
            chk_lines("R4 R5 lines in sweep");
        end

        // R5/R6: floating hold, pulls, pull-up precedence.
        wreg(12'h400, 32'hFF);
        wreg(12'h3FC, 32'h96);
        wreg(12'h400, 32'h00);
        check("R5 float hold", {24'b0, pout_p}, 32'h96);
        check("R6 fixed pulls", {24'b0, pout_f}, 32'hF2);
        wreg(12'h510, 32'h0F);
        check("R5 pull-up", {24'b0, pout_p}, 32'h9F);
        wreg(12'h514, 32'hF0);
        check("R5 pull-down", {24'b0, pout_p}, 32'h0F);
        wreg(12'h510, 32'h11);
        wreg(12'h514, 32'h11);
        check("R5 pull-up wins", {24'b0, pout_p}, 32'h1F);
        chk_lines("R5 model lines");
        acc(1'b0, 12'h510, 0);
        check("R6 pull-up readback", cap_rd, 32'h11);
        check("R8 fixed pull offset zero", cap_rd_f, 32'h0);
        acc(1'b0, 12'h514, 0);
        check("R6 pull-down readback", cap_rd, 32'h11);

        // R7: setting registers store the low byte.
        for (int k = 0; k < 7; k++) begin
            wreg(cfg_off[k], 32'hDEAD_BE00 | 32'(8'h3C + 8'(k * 17)));
            check("R7 write no err", {31'b0, cap_err}, 32'h0);
            acc(1'b0, cfg_off[k], 0);
            check("R7 setting readback", cap_rd, 32'(8'h3C + 8'(k * 17)));
        end

        // R10: unmapped offsets read zero, flag, and change nothing.
        wreg(12'h400, 32'h3C);
        for (int k = 0; k < 9; k++) begin
            wreg(bad_off[k], 32'hFFFF_FFFF);
            check("R10 write err", {31'b0, cap_err}, 32'h1);
            acc(1'b0, bad_off[k], 0);
            check("R10 read zero", cap_rd, 32'h0);
            check("R10 read err", {31'b0, cap_err}, 32'h1);
            check("R10 err is a pulse", {31'b0, err_p}, 32'h0);
        end
        acc(1'b0, 12'h400, 0);
        check("R10 dir untouched", cap_rd, 32'h3C);
        chk_lines("R10 lines untouched");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule